// File: doc/BRIEF.md
# Masked System Register File

This block is a small bank of architectural control registers. Every logical register index carries a fixed attribute record. The record gives its storage mapping, a reset value and four 64-bit bit-masks. The masks mark bits that software should keep at zero (reserved-zero), bits it should keep at one (reserved-one), bits that always read as zero (forced-zero) and bits that always read as one (forced-one). Forced bits ignore writes. Storage is a set of slots. A logical register either owns one slot as a full 64-bit value, or joins two slots as the low and high 32-bit halves of a 64-bit view. Two logical registers may share slots. In that case the masks applied are always those of the index being accessed.

Access goes through one port. An index selects the register. The read value and two warning flags are combinational from the index. A write is applied at the next rising clock edge. The warnings report reserved-bit violations in the stored contents of the addressed register, so software sees when a reserved field holds an illegal value. An asynchronous active-low reset, released through a two-stage synchronizer, loads every slot at once.

Top module: `sysreg_mask_bank`

## Requirements
- R1: The default configuration has six logical registers (indices 0 to 5) and six slots. In the list below, "lo" is the low slot and "hi" is the high slot (hi 0 means single-slot). Masks not listed are zero.
  - Index 0: lo 0, hi 0, reset 0x0123456789ABCDEF.
  - Index 1: lo 1, hi 2, reset 0x000000A50000005A, forced-zero 0xFFFF000000000000, forced-one 0x1.
  - Index 2: lo 1, hi 0, reset 0, forced-one 0x8000000000000000, reserved-zero 0x7FFFFFFF00000000.
  - Index 3: lo 3, hi 0, reset 0x30, reserved-one 0x30, reserved-zero 0xFF40.
  - Index 4: lo 4, hi 5, reset 0, forced-zero 0x00000F00000000F0, forced-one 0x100, reserved-zero 0x00F0000000000000.
  - Index 5: lo 5, hi 0, reset 0, reserved-one 0x1.
- R2: While reset is asserted, every slot holds a reset value and reads reflect it at once. A slot's reset value is the reset value of the lowest-numbered register that maps it, after the write filter of R3 (applied through R4/R5 as a write would be). A slot mapped by no register resets to 0.
- R3: A write stores (data AND NOT (forced-zero OR forced-one)) OR forced-one, using the masks of the written index.
- R4: For a two-slot register, bits 31:0 of the filtered write go to the low slot and bits 63:32 go to the high slot. Both are zero-extended. The read assembles {high slot[31:0], low slot[31:0]}.
- R5: For a single-slot register, the full 64-bit filtered value is written to the low slot, and a read returns that slot as a whole.
- R6: A read returns (assembled value AND NOT forced-zero) OR forced-one, using the masks of the index being read, including when the slots are shared with another index.
- R7: The reserved-zero warning is high when the assembled value of the addressed register has any bit set inside its reserved-zero mask.
- R8: The reserved-one warning is high when the assembled value of the addressed register has any bit clear inside its reserved-one mask.
- R9: A write takes effect at the next rising clock edge. A read of the same index in the write cycle returns the old value.
- R10: An index of 6 or above reads as 0 with both warnings low, and a write to it changes no slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| idx_i | input | IDX_W (3) | Logical register index |
| we_i | input | 1 | Write enable |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Masked read data of the indexed register |
| res0_warn_o | output | 1 | Reserved-zero violation on the addressed register |
| res1_warn_o | output | 1 | Reserved-one violation on the addressed register |

## Verification
A write and a combinational read of the same register can occur in the same cycle, and so can a write through one index and a read through an alias that shares its slots. The bench drives each write with the index held. Before the edge it compares the read data against the model's old value, and after the edge it sweeps every index, aliases included, against the model's new value. Every write pattern goes to every index, invalid ones included, so a write through one view is always judged through every other view of the same slots.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

  localparam int unsigned DATA_W        = 64;
  localparam int unsigned HALF_W        = DATA_W / 2;
  localparam int unsigned SLOT_IDX_W    = 8;
  localparam int unsigned NUM_REGS_DEF  = 6;
  localparam int unsigned NUM_SLOTS_DEF = 6;

  typedef logic [DATA_W-1:0] word_t;

  // Attribute record of one logical register. hi == 0 means single slot.
  typedef struct packed {
    logic [SLOT_IDX_W-1:0] lo;
    logic [SLOT_IDX_W-1:0] hi;
    word_t                 rst;
    word_t                 res0;
    word_t                 res1;
    word_t                 raz;
    word_t                 rao;
  } reg_attr_t;

  function automatic reg_attr_t reg_attr(input int unsigned idx);
    reg_attr_t a;
    a = '0;
    case (idx)
      0: begin
        a.lo  = 8'd0;
        a.rst = 64'h0123_4567_89AB_CDEF;
      end
      1: begin
        a.lo  = 8'd1;
        a.hi  = 8'd2;
        a.rst = 64'h0000_00A5_0000_005A;
        a.raz = 64'hFFFF_0000_0000_0000;
        a.rao = 64'h0000_0000_0000_0001;
      end
      2: begin
        a.lo   = 8'd1;
        a.rao  = 64'h8000_0000_0000_0000;
        a.res0 = 64'h7FFF_FFFF_0000_0000;
      end
      3: begin
        a.lo   = 8'd3;
        a.rst  = 64'h0000_0000_0000_0030;
        a.res0 = 64'h0000_0000_0000_FF40;
        a.res1 = 64'h0000_0000_0000_0030;
      end
      4: begin
        a.lo   = 8'd4;
        a.hi   = 8'd5;
        a.raz  = 64'h0000_0F00_0000_00F0;
        a.rao  = 64'h0000_0000_0000_0100;
        a.res0 = 64'h00F0_0000_0000_0000;
      end
      5: begin
        a.lo   = 8'd5;
        a.res1 = 64'h0000_0000_0000_0001;
      end
      default: a = '0;
    endcase
    return a;
  endfunction

  function automatic word_t write_filter(input reg_attr_t a, input word_t d);
    return (d & ~(a.raz | a.rao)) | a.rao;
  endfunction

  // Content a given slot receives when a filtered value v is written through a.
  function automatic logic slot_hit(input reg_attr_t a, input int unsigned s);
    return (int'(a.lo) == int'(s)) || ((a.hi != '0) && (int'(a.hi) == int'(s)));
  endfunction

  function automatic word_t slot_part(input reg_attr_t a, input int unsigned s,
                                      input word_t v);
    word_t r;
    r = '0;
    if (a.hi == '0) begin
      r = v;
    end else if (int'(a.hi) == int'(s)) begin
      r[HALF_W-1:0] = v[DATA_W-1:HALF_W];
    end else begin
      r[HALF_W-1:0] = v[HALF_W-1:0];
    end
    return r;
  endfunction

  // Lowest-numbered register that maps the slot supplies its reset content.
  function automatic word_t slot_reset(input int unsigned s, input int unsigned nregs);
    word_t     r;
    reg_attr_t a;
    r = '0;
    for (int k = int'(nregs) - 1; k >= 0; k--) begin
      a = reg_attr(k);
      if (slot_hit(a, s)) r = slot_part(a, s, write_filter(a, a.rst));
    end
    return r;
  endfunction

endpackage

// File: rtl/sysreg_write_path.sv
module sysreg_write_path
  import sysreg_pkg::*;
#(
  parameter int unsigned NUM_REGS  = NUM_REGS_DEF,
  parameter int unsigned NUM_SLOTS = NUM_SLOTS_DEF,
  parameter int unsigned IDX_W     = 3
) (
  input  logic [IDX_W-1:0]                idx_i,
  input  logic                            we_i,
  input  word_t                           wdata_i,
  output logic [NUM_SLOTS-1:0]            slot_we_o,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_wdata_o
);

  reg_attr_t attr;
  logic      idx_ok;
  word_t     filtered;

  always_comb begin
    attr     = reg_attr(32'(idx_i));
    idx_ok   = 32'(idx_i) < NUM_REGS;
    filtered = write_filter(attr, wdata_i);
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_comb begin
      slot_we_o[s]    = we_i && idx_ok && slot_hit(attr, s);
      slot_wdata_o[s] = slot_part(attr, s, filtered);
    end
  end

endmodule

// File: rtl/sysreg_slot_store.sv
module sysreg_slot_store
  import sysreg_pkg::*;
#(
  parameter int unsigned NUM_REGS  = NUM_REGS_DEF,
  parameter int unsigned NUM_SLOTS = NUM_SLOTS_DEF
) (
  input  logic                             clk_i,
  input  logic                             rst_n_i,
  input  logic [NUM_SLOTS-1:0]             slot_we_i,
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_wdata_i,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_q_o
);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam word_t SLOT_RST = slot_reset(s, NUM_REGS);
    word_t slot_d;
    word_t slot_q;

    always_comb begin
      slot_d = slot_q;
      if (slot_we_i[s]) slot_d = slot_wdata_i[s];
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
        slot_q <= SLOT_RST;
      end else if (slot_we_i[s]) begin
        slot_q <= slot_d;
      end
    end

    assign slot_q_o[s] = slot_q;
  end

endmodule

// File: rtl/sysreg_read_path.sv
module sysreg_read_path
  import sysreg_pkg::*;
#(
  parameter int unsigned NUM_REGS  = NUM_REGS_DEF,
  parameter int unsigned NUM_SLOTS = NUM_SLOTS_DEF,
  parameter int unsigned IDX_W     = 3
) (
  input  logic [IDX_W-1:0]                idx_i,
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_q_i,
  output word_t                           rdata_o,
  output logic                            res0_warn_o,
  output logic                            res1_warn_o
);

  reg_attr_t attr;
  logic      idx_ok;
  word_t     lo_val;
  word_t     hi_val;
  word_t     raw;

  always_comb begin
    attr   = reg_attr(32'(idx_i));
    idx_ok = 32'(idx_i) < NUM_REGS;
    lo_val = '0;
    hi_val = '0;
    for (int s = 0; s < int'(NUM_SLOTS); s++) begin
      if (int'(attr.lo) == s) lo_val = slot_q_i[s];
      if (int'(attr.hi) == s) hi_val = slot_q_i[s];
    end
    if (attr.hi != '0) raw = {hi_val[HALF_W-1:0], lo_val[HALF_W-1:0]};
    else               raw = lo_val;
  end

  always_comb begin
    rdata_o     = '0;
    res0_warn_o = 1'b0;
    res1_warn_o = 1'b0;
    if (idx_ok) begin
      rdata_o     = (raw & ~attr.raz) | attr.rao;
      res0_warn_o = |(raw & attr.res0);
      res1_warn_o = (raw & attr.res1) != attr.res1;
    end
  end

endmodule

// File: rtl/sysreg_mask_bank.sv
module sysreg_mask_bank
  import sysreg_pkg::*;
#(
  parameter int unsigned NUM_REGS  = NUM_REGS_DEF,
  parameter int unsigned NUM_SLOTS = NUM_SLOTS_DEF,
  parameter int unsigned IDX_W     = 3
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              we_i,
  input  logic [63:0]       wdata_i,
  output logic [63:0]       rdata_o,
  output logic              res0_warn_o,
  output logic              res1_warn_o
);

  logic [1:0]                      rst_pipe_q;
  logic [1:0]                      rst_pipe_d;
  logic                            rst_sync_n;
  logic [NUM_SLOTS-1:0]            slot_we;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_wdata;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_q;

  // Reset asserts at once and releases two clock edges later.
  always_comb rst_pipe_d = {rst_pipe_q[0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_pipe_q <= '0;
    else          rst_pipe_q <= rst_pipe_d;
  end

  assign rst_sync_n = rst_pipe_q[1];

  sysreg_write_path #(
    .NUM_REGS (NUM_REGS),
    .NUM_SLOTS(NUM_SLOTS),
    .IDX_W    (IDX_W)
  ) wr_i (
    .idx_i       (idx_i),
    .we_i        (we_i),
    .wdata_i     (wdata_i),
    .slot_we_o   (slot_we),
    .slot_wdata_o(slot_wdata)
  );

  sysreg_slot_store #(
    .NUM_REGS (NUM_REGS),
    .NUM_SLOTS(NUM_SLOTS)
  ) store_i (
    .clk_i       (clk_i),
    .rst_n_i     (rst_sync_n),
    .slot_we_i   (slot_we),
    .slot_wdata_i(slot_wdata),
    .slot_q_o    (slot_q)
  );

  sysreg_read_path #(
    .NUM_REGS (NUM_REGS),
    .NUM_SLOTS(NUM_SLOTS),
    .IDX_W    (IDX_W)
  ) rd_i (
    .idx_i      (idx_i),
    .slot_q_i   (slot_q),
    .rdata_o    (rdata_o),
    .res0_warn_o(res0_warn_o),
    .res1_warn_o(res1_warn_o)
  );

endmodule

// File: rtl/sysreg_mask_bank_chk.sv
module sysreg_mask_bank_chk
  import sysreg_pkg::*;
#(
  parameter int unsigned NUM_REGS = NUM_REGS_DEF,
  parameter int unsigned IDX_W    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] idx,
  input logic             we,
  input logic [63:0]      wdata,
  input logic [63:0]      rdata,
  input logic             w0,
  input logic             w1
);

  reg_attr_t a;
  logic      valid;

  always_comb begin
    a     = reg_attr(32'(idx));
    valid = 32'(idx) < NUM_REGS;
  end

  p_forced_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((rdata & a.rao) == a.rao));

  p_forced_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((rdata & a.raz) == '0));

  p_bad_index_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (rdata == '0 && !w0 && !w1));

  p_res0_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (w0 == ((rdata & a.res0) != '0)));

  p_res1_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (w1 == ((rdata & a.res1) != a.res1)));

  // Written value, filtered and masked, is what the same index reads next cycle.
  p_write_seen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && valid) |=> ((idx != $past(idx)) ||
      (rdata == (((($past(wdata) & ~($past(a.raz) | $past(a.rao))) | $past(a.rao))
                  & ~$past(a.raz)) | $past(a.rao)))));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ((idx != $past(idx)) || $stable(rdata)));

endmodule

bind sysreg_mask_bank sysreg_mask_bank_chk #(
  .NUM_REGS(NUM_REGS),
  .IDX_W   (IDX_W)
) chk_i (
  .clk  (clk_i),
  .rst_n(rst_sync_n),
  .idx  (idx_i),
  .we   (we_i),
  .wdata(wdata_i),
  .rdata(rdata_o),
  .w0   (res0_warn_o),
  .w1   (res1_warn_o)
);

// File: tb/sysreg_mask_bank_tb.sv
module sysreg_mask_bank_tb_top;

  typedef struct {
    int          lo;
    int          hi;
    logic [63:0] rst, res0, res1, raz, rao;
  } attr_t;

  logic        clk;
  logic        rst_n;
  logic [2:0]  idx;
  logic        we;
  logic [63:0] wdata;
  logic [63:0] rdata;
  logic        w0, w1;

  logic [63:0] m [6];
  int          n_checks = 0;
  int          n_err    = 0;

  sysreg_mask_bank dut_i (
    .clk_i      (clk),
    .rst_n_i    (rst),
    .idx_i      (idx),
    .we_i       (we),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .res0_warn_o(w0),
    .res1_warn_o(w1)
  );

  logic rst;
  assign rst = rst_n;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Attribute table as stated in R1.
  function automatic attr_t tbl(input int i);
    attr_t a;
    a = '{lo: 0, hi: 0, rst: 64'd0, res0: 64'd0, res1: 64'd0, raz: 64'd0, rao: 64'd0};
    case (i)
      0: a.rst = 64'h0123_4567_89AB_CDEF;
      1: begin a.lo = 1; a.hi = 2; a.rst = 64'h0000_00A5_0000_005A;
               a.raz = 64'hFFFF_0000_0000_0000; a.rao = 64'h1; end
      2: begin a.lo = 1; a.rao = 64'h8000_0000_0000_0000;
               a.res0 = 64'h7FFF_FFFF_0000_0000; end
      3: begin a.lo = 3; a.rst = 64'h30; a.res0 = 64'hFF40; a.res1 = 64'h30; end
      4: begin a.lo = 4; a.hi = 5; a.raz = 64'h0000_0F00_0000_00F0;
               a.rao = 64'h100; a.res0 = 64'h00F0_0000_0000_0000; end
      5: begin a.lo = 5; a.res1 = 64'h1; end
      default: ;
    endcase
    return a;
  endfunction

  task automatic model_write(input int i, input logic [63:0] d);
    attr_t       a;
    logic [63:0] v;
    if (i >= 6) return;
    a = tbl(i);
    v = (d & ~(a.raz | a.rao)) | a.rao;
    if (a.hi != 0) begin
      m[a.lo] = {32'd0, v[31:0]};
      m[a.hi] = {32'd0, v[63:32]};
    end else begin
      m[a.lo] = v;
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < 6; s++) m[s] = 64'd0;
    for (int r = 5; r >= 0; r--) model_write(r, tbl(r).rst);
  endtask

  task automatic model_read(input int i, output logic [63:0] rd,
                            output logic e0, output logic e1);
    attr_t       a;
    logic [63:0] raw;
    rd = 64'd0; e0 = 1'b0; e1 = 1'b0;
    if (i >= 6) return;
    a   = tbl(i);
    raw = (a.hi != 0) ? {m[a.hi][31:0], m[a.lo][31:0]} : m[a.lo];
    rd  = (raw & ~a.raz) | a.rao;
    e0  = |(raw & a.res0);
    e1  = (raw & a.res1) != a.res1;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string read_tag(input int i);
    if (i >= 6)           return "R10 read";
    if (i == 2 || i == 5) return "R6 alias read";
    if (i == 1 || i == 4) return "R4 R6 paired read";
    return "R5 R6 single read";
  endfunction

  // Compare one index at the current time (away from edges).
  task automatic check_idx(input int i, input string pre);
    logic [63:0] er;
    logic        e0, e1;
    idx = i[2:0];
    #1;
    model_read(i, er, e0, e1);
    chk({pre, " ", read_tag(i)}, rdata, er);
    chk({pre, " R7 res0 warn"}, {63'd0, w0}, {63'd0, e0});
    chk({pre, " R8 res1 warn"}, {63'd0, w1}, {63'd0, e1});
  endtask

  task automatic sweep(input string pre);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check_idx(i, pre);
    end
  endtask

  task automatic do_write(input int i, input logic [63:0] d);
    logic [63:0] er;
    logic        e0, e1;
    @(negedge clk);
    idx = i[2:0]; we = 1'b1; wdata = d;
    #1;
    model_read(i, er, e0, e1);
    chk("R9 same-cycle old value", rdata, er);
    @(posedge clk);
    #1;
    we = 1'b0;
    model_write(i, d);
  endtask

  initial begin
    #2_000_000;
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    logic [63:0] pats [5];
    pats[0] = 64'd0;
    pats[1] = '1;
    pats[2] = 64'hAAAA_AAAA_AAAA_AAAA;
    pats[3] = 64'h5555_5555_5555_5555;
    pats[4] = 64'hFEDC_BA98_7654_3210;

    rst_n = 1'b0; we = 1'b0; idx = '0; wdata = '0;
    model_reset();
    repeat (2) @(negedge clk);
    // R1 R2: reset contents visible while reset is held
    sweep("R1 R2 reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    sweep("R2 after release");

    // R3 R4 R5: every pattern through every index, then every view
    for (int i = 0; i < 8; i++) begin
      for (int p = 0; p < 5; p++) begin
        do_write(i, pats[p] ^ {8{i[7:0]}});
        sweep("R3");
      end
    end

    // R2: reset in mid-run restores reset contents at once
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    model_reset();
    for (int i = 0; i < 8; i++) begin
      idx = i[2:0];
      #1;
      check_idx(i, "R2 mid-run reset");
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    do_write(3, 64'h0000_0000_0000_FFCF);
    sweep("R7 R8 after reset");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule